// File: doc/BRIEF.md
# Quad-Rate Two-Word Burst Static Memory

This block is a cycle-accurate, synthesizable model of a static memory with a write-data bus that only carries data in and a read-data bus that only carries data out. The two buses are never turned around, so a read and a write can both run in every cycle. One address bus serves both ports. Every access moves a fixed pair of words that share a single address. The read-data bus and the write-data bus each carry one word per half-cycle, so each runs at double data rate.

The model runs on one clock, `clk`, that ticks at twice the memory cycle rate. Its rising edges alternate between the primary edge and the complementary edge of the memory clock pair. After reset the first active edge is a primary edge, and the block reports which kind of edge comes next on `k_phase`.

- A read is requested on a primary edge, together with its address.
- A write is requested on a primary edge, together with its first data word.
- The write address and the second data word follow on the next complementary edge.

Completed writes reach the array one edge later through a commit register. Reads see that register through a bypass. The `lat_mode` input selects the read latency: a full cycle, or one and a half cycles.

Top module: `qdr_b2_sram`

## Requirements
- R1: A read and a write can be issued in the same cycle on the separate data buses, and both complete correctly.
- R2: A read address is taken from `addr` on a primary edge, and a write address is taken from `addr` on the complementary edge that follows. `k_phase` is 1 when the next active edge is primary: it is 1 after reset and toggles on every active edge.
- R3: A write takes word 0 from `wdata` on its primary edge and word 1 on the following complementary edge. Word 0 goes to burst index 0 of the address and word 1 to burst index 1. A read drives word 0 and then word 1 on two consecutive edges.
- R4: A read whose primary edge is edge n presents word 0 after edge n+2 when `lat_mode` is 0, and after edge n+3 when `lat_mode` is 1. `lat_mode` is changed only while no read is in flight.
- R5: `rd_sel_n` and `wr_sel_n` are active low and independent. A high select issues nothing. Selects and addresses seen on a complementary edge start no access.
- R6: Lane i of a word is bits [9i+8:9i]. `byte_wr_n[i]` is sampled with each data word, and a 0 writes the lane while a 1 leaves it unchanged.
- R7: A read returns the combined effect of every write issued in the same cycle or an earlier one, including a write still held in the commit register. A write issued in a later cycle is not seen.
- R8: `rd_valid` is high exactly on the edges that carry read words. While it is low, `rdata` keeps its last value.
- R9: Reset (`rst_n` low) clears `rd_valid` and `rdata` at once and discards in-flight reads and pending writes, so that none of them completes. Reset is released through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; rising edges alternate primary / complementary |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| lat_mode | input | 1 | 0: one-cycle read latency; 1: one-and-a-half-cycle latency |
| rd_sel_n | input | 1 | Active-low read select, sampled on primary edges |
| wr_sel_n | input | 1 | Active-low write select, sampled on primary edges |
| addr | input | ADDR_W | Shared address: read address on primary edges, write address on complementary edges |
| wdata | input | LANES*9 | Write data, one word per edge |
| byte_wr_n | input | LANES | Active-low per-lane write enables, sampled with each word |
| rdata | output | LANES*9 | Read data, one word per edge |
| rd_valid | output | 1 | High when `rdata` carries a read word |
| k_phase | output | 1 | High when the next active edge is a primary edge |

## Verification
The case this block must get right is a read and a write that fall in the same cycle. The bench issues both in the same cycle to the same address, with full and partial lane masks. It also issues a write to an address one cycle before or one cycle after a read of that address. The new data is then waiting in the commit register or in the array, and the read must pick it up or miss it as R7 states. A behavioural reference memory applies each cycle's write before that cycle's read and schedules the expected words at the edges R4 gives. Every edge is then compared: valid flag, data and the held value.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
  localparam int LANE_W = 9;
  typedef enum logic {PH_K = 1'b0, PH_KN = 1'b1} qdr_phase_e;
endpackage

// File: rtl/qdr_rst_sync.sv
module qdr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      stage1 <= 1'b1;
      rst_q  <= stage1;
    end
  end
endmodule

// File: rtl/qdr_wr_path.sv
// Write capture: word 0 on the primary edge, address and word 1 on the
// complementary edge, then a commit register that lives for one edge.
module qdr_wr_path #(
  parameter  int ADDR_W = 4,
  parameter  int LANES  = 4,
  localparam int WORD_W = LANES * qdr_pkg::LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_k,
  input  logic              wr_sel_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [LANES-1:0]  byte_wr_n,
  output logic              cm_valid,
  output logic [ADDR_W-1:0] cm_addr,
  output logic [WORD_W-1:0] cm_w0,
  output logic [WORD_W-1:0] cm_w1,
  output logic [LANES-1:0]  cm_be0,
  output logic [LANES-1:0]  cm_be1
);
  logic              hold_v, hold_v_nx;
  logic [WORD_W-1:0] hold_w0;
  logic [LANES-1:0]  hold_be0;
  logic              cm_valid_nx;
  logic              hold_ld, cm_ld;

  always_comb begin
    hold_ld     = is_k && !wr_sel_n;
    cm_ld       = !is_k && hold_v;
    hold_v_nx   = is_k ? !wr_sel_n : 1'b0;
    cm_valid_nx = cm_ld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v   <= 1'b0;
      cm_valid <= 1'b0;
    end else begin
      hold_v   <= hold_v_nx;
      cm_valid <= cm_valid_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (hold_ld) begin
      hold_w0  <= wdata;
      hold_be0 <= ~byte_wr_n;
    end
  end

  always_ff @(posedge clk) begin
    if (cm_ld) begin
      cm_addr <= addr;
      cm_w0   <= hold_w0;
      cm_w1   <= wdata;
      cm_be0  <= hold_be0;
      cm_be1  <= ~byte_wr_n;
    end
  end
endmodule

// File: rtl/qdr_array.sv
// Storage indexed by {address, burst bit}; two-word lane-masked write port and
// a read port that merges a same-edge commit over the stored data.
module qdr_array #(
  parameter  int ADDR_W = 4,
  parameter  int LANES  = 4,
  localparam int LW     = qdr_pkg::LANE_W,
  localparam int WORD_W = LANES * LW,
  localparam int DEPTH  = 1 << (ADDR_W + 1)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_w0,
  input  logic [WORD_W-1:0] wr_w1,
  input  logic [LANES-1:0]  wr_be0,
  input  logic [LANES-1:0]  wr_be1,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_w0,
  output logic [WORD_W-1:0] rd_w1
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] raw0, raw1;
  logic              hit;

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (wr_en && wr_be0[l]) mem[{wr_addr, 1'b0}][l*LW +: LW] <= wr_w0[l*LW +: LW];
      if (wr_en && wr_be1[l]) mem[{wr_addr, 1'b1}][l*LW +: LW] <= wr_w1[l*LW +: LW];
    end
  end

  always_comb begin
    raw0 = mem[{rd_addr, 1'b0}];
    raw1 = mem[{rd_addr, 1'b1}];
    hit  = wr_en && (wr_addr == rd_addr);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rd_w0[g*LW +: LW] = (hit && wr_be0[g]) ? wr_w0[g*LW +: LW] : raw0[g*LW +: LW];
    assign rd_w1[g*LW +: LW] = (hit && wr_be1[g]) ? wr_w1[g*LW +: LW] : raw1[g*LW +: LW];
  end
endmodule

// File: rtl/qdr_rd_pipe.sv
// Read request register, snapshot on the next primary edge, and a two-slot
// word delay line feeding the registered output.
module qdr_rd_pipe #(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_k,
  input  logic              rd_sel_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              lat_mode,
  input  logic [WORD_W-1:0] snap_w0,
  input  logic [WORD_W-1:0] snap_w1,
  output logic [ADDR_W-1:0] req_addr,
  output logic [WORD_W-1:0] rdata,
  output logic              rd_valid
);
  logic              req_v, req_v_nx, req_ld, snap;
  logic              q0_v, q0_v_nx, q1_v, q1_v_nx;
  logic [WORD_W-1:0] q0_d, q0_d_nx, q1_d, q1_d_nx;
  logic              out_v_nx;
  logic [WORD_W-1:0] out_d_nx;

  always_comb begin
    req_ld   = is_k && !rd_sel_n;
    req_v_nx = is_k ? !rd_sel_n : req_v;
    snap     = is_k && req_v;
    out_v_nx = q0_v;
    out_d_nx = q0_v ? q0_d : rdata;
    q0_v_nx  = q1_v;
    q0_d_nx  = q1_d;
    q1_v_nx  = 1'b0;
    q1_d_nx  = q1_d;
    if (snap) begin
      if (!lat_mode) begin
        out_v_nx = 1'b1;
        out_d_nx = snap_w0;
        q0_v_nx  = 1'b1;
        q0_d_nx  = snap_w1;
      end else begin
        q0_v_nx  = 1'b1;
        q0_d_nx  = snap_w0;
        q1_v_nx  = 1'b1;
        q1_d_nx  = snap_w1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_v    <= 1'b0;
      q0_v     <= 1'b0;
      q1_v     <= 1'b0;
      rd_valid <= 1'b0;
      rdata    <= '0;
    end else begin
      req_v    <= req_v_nx;
      q0_v     <= q0_v_nx;
      q1_v     <= q1_v_nx;
      rd_valid <= out_v_nx;
      rdata    <= out_d_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (req_ld) req_addr <= addr;
    q0_d <= q0_d_nx;
    q1_d <= q1_d_nx;
  end
endmodule

// File: rtl/qdr_b2_sram.sv
module qdr_b2_sram #(
  parameter  int ADDR_W = 4,
  parameter  int LANES  = 4,
  localparam int WORD_W = LANES * qdr_pkg::LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lat_mode,
  input  logic              rd_sel_n,
  input  logic              wr_sel_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [LANES-1:0]  byte_wr_n,
  output logic [WORD_W-1:0] rdata,
  output logic              rd_valid,
  output logic              k_phase
);
  import qdr_pkg::*;

  logic              rst_q;
  qdr_phase_e        ph_q, ph_nx;
  logic              is_k;
  logic              cm_valid;
  logic [ADDR_W-1:0] cm_addr, req_addr;
  logic [WORD_W-1:0] cm_w0, cm_w1, snap_w0, snap_w1;
  logic [LANES-1:0]  cm_be0, cm_be1;

  qdr_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q(rst_q));

  always_comb begin
    is_k    = (ph_q == PH_K);
    ph_nx   = is_k ? PH_KN : PH_K;
    k_phase = is_k;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) ph_q <= PH_K;
    else        ph_q <= ph_nx;
  end

  qdr_wr_path #(.ADDR_W(ADDR_W), .LANES(LANES)) u_wr (
    .clk(clk), .rst_n(rst_q), .is_k(is_k), .wr_sel_n(wr_sel_n), .addr(addr),
    .wdata(wdata), .byte_wr_n(byte_wr_n), .cm_valid(cm_valid), .cm_addr(cm_addr),
    .cm_w0(cm_w0), .cm_w1(cm_w1), .cm_be0(cm_be0), .cm_be1(cm_be1)
  );

  qdr_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_mem (
    .clk(clk), .wr_en(cm_valid && is_k), .wr_addr(cm_addr), .wr_w0(cm_w0),
    .wr_w1(cm_w1), .wr_be0(cm_be0), .wr_be1(cm_be1), .rd_addr(req_addr),
    .rd_w0(snap_w0), .rd_w1(snap_w1)
  );

  qdr_rd_pipe #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_rd (
    .clk(clk), .rst_n(rst_q), .is_k(is_k), .rd_sel_n(rd_sel_n), .addr(addr),
    .lat_mode(lat_mode), .snap_w0(snap_w0), .snap_w1(snap_w1),
    .req_addr(req_addr), .rdata(rdata), .rd_valid(rd_valid)
  );
endmodule

// File: rtl/qdr_b2_sram_chk.sv
module qdr_b2_sram_chk #(
  parameter int WORD_W = 36
) (
  input logic              clk,
  input logic              rst_q,
  input logic              k_phase,
  input logic              rd_sel_n,
  input logic              lat_mode,
  input logic              rd_valid,
  input logic [WORD_W-1:0] rdata
);
  logic armed;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R2: edge kinds alternate
  a_r2_phase_alt: assert property (@(posedge clk) disable iff (!rst_q)
    armed |-> (k_phase != $past(k_phase)));

  // R4: short latency
  a_r4_lat_short: assert property (@(posedge clk) disable iff (!rst_q)
    (k_phase && !rd_sel_n && !lat_mode) |-> ##3 rd_valid);

  // R4: long latency
  a_r4_lat_long: assert property (@(posedge clk) disable iff (!rst_q)
    (k_phase && !rd_sel_n && lat_mode) |-> ##4 rd_valid);

  // R3: words come in pairs
  a_r3_pair: assert property (@(posedge clk) disable iff (!rst_q)
    (armed && $rose(rd_valid)) |=> rd_valid);

  // R8: output held while idle
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_q)
    (armed && !rd_valid) |-> $stable(rdata));
endmodule

bind qdr_b2_sram qdr_b2_sram_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_q(rst_q), .k_phase(k_phase), .rd_sel_n(rd_sel_n),
  .lat_mode(lat_mode), .rd_valid(rd_valid), .rdata(rdata)
);

// File: tb/qdr_b2_sram_tb.sv
`timescale 1ns/1ps
module qdr_b2_sram_tb;
  localparam int ADDR_W = 4;
  localparam int LANES  = 4;
  localparam int WORD_W = LANES * 9;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              lat_mode;
  logic              rd_sel_n, wr_sel_n;
  logic [ADDR_W-1:0] addr;
  logic [WORD_W-1:0] wdata;
  logic [LANES-1:0]  byte_wr_n;
  logic [WORD_W-1:0] rdata;
  logic              rd_valid, k_phase;

  always #2.5 clk = ~clk;

  qdr_b2_sram #(.ADDR_W(ADDR_W), .LANES(LANES)) u_dut (
    .clk(clk), .rst_n(rst_n), .lat_mode(lat_mode), .rd_sel_n(rd_sel_n),
    .wr_sel_n(wr_sel_n), .addr(addr), .wdata(wdata), .byte_wr_n(byte_wr_n),
    .rdata(rdata), .rd_valid(rd_valid), .k_phase(k_phase)
  );

  int checks = 0;
  int bad = 0;
  int e = 0;
  bit finished = 0;
  string idle_tag = "R8";
  logic [WORD_W-1:0] last_out;
  logic [WORD_W-1:0] mdl [int];
  logic [WORD_W-1:0] exp_d [int];
  string exp_tag [int];

  function automatic logic [WORD_W-1:0] pat(input int a, input int b);
    return (WORD_W'(a) * 36'h0_0102_0305 + WORD_W'(b) * 36'h9_8000_0011) ^ 36'hA_5C3F_0E17;
  endfunction

  function automatic void mdl_wr(input int idx, input logic [WORD_W-1:0] d,
                                 input logic [LANES-1:0] bw);
    logic [WORD_W-1:0] old;
    old = mdl.exists(idx) ? mdl[idx] : '0;
    for (int l = 0; l < LANES; l++)
      if (!bw[l]) old[l*9 +: 9] = d[l*9 +: 9];
    mdl[idx] = old;
  endfunction

  task automatic check_edge();
    logic exp_k;
    exp_k = (e % 2) == 1;
    checks++;
    if (k_phase !== exp_k) begin
      bad++;
      $display("FAIL R2: edge %0d k_phase=%b expected %b", e, k_phase, exp_k);
    end
    checks++;
    if (exp_d.exists(e)) begin
      if (rd_valid !== 1'b1 || rdata !== exp_d[e]) begin
        bad++;
        $display("FAIL %s: edge %0d valid=%b data=%h expected valid=1 data=%h",
                 exp_tag[e], e, rd_valid, rdata, exp_d[e]);
      end
      last_out = exp_d[e];
      exp_d.delete(e);
      exp_tag.delete(e);
    end else if (rd_valid !== 1'b0 || rdata !== last_out) begin
      bad++;
      $display("FAIL %s: edge %0d valid=%b data=%h expected valid=0 data=%h",
               idle_tag, e, rd_valid, rdata, last_out);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    check_edge();
    e++;
  endtask

  // One memory cycle: primary edge then complementary edge.
  task automatic cyc(input bit rd, input int ra, input bit wr, input int wa,
                     input logic [WORD_W-1:0] d0, input logic [WORD_W-1:0] d1,
                     input logic [LANES-1:0] b0, input logic [LANES-1:0] b1,
                     input bit junk, input bit apply, input string tag);
    int lat;
    rd_sel_n = !rd; wr_sel_n = !wr; addr = ADDR_W'(ra); wdata = d0; byte_wr_n = b0;
    if (wr && apply) begin
      mdl_wr(wa * 2, d0, b0);
      mdl_wr(wa * 2 + 1, d1, b1);
    end
    if (rd && apply) begin
      lat = lat_mode ? 3 : 2;
      exp_d[e + lat]       = mdl[ra * 2];
      exp_tag[e + lat]     = tag;
      exp_d[e + lat + 1]   = mdl[ra * 2 + 1];
      exp_tag[e + lat + 1] = tag;
    end
    step();
    rd_sel_n = !junk; wr_sel_n = !junk; addr = ADDR_W'(wa); wdata = d1; byte_wr_n = b1;
    step();
    rd_sel_n = 1'b1; wr_sel_n = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, pat(i, 7), pat(i, 9), '0, '0, 0, 1, "R8");
  endtask

  task automatic rd(input int a, input string tag);
    cyc(1, a, 0, 0, '0, '0, '1, '1, 0, 1, tag);
  endtask

  task automatic wr(input int a, input logic [WORD_W-1:0] d0, input logic [WORD_W-1:0] d1,
                    input logic [LANES-1:0] b0, input logic [LANES-1:0] b1);
    cyc(0, 0, 1, a, d0, d1, b0, b1, 0, 1, "R6");
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    rd_sel_n = 1'b1; wr_sel_n = 1'b1;
    #1;
    checks++;
    if (rd_valid !== 1'b0 || rdata !== '0) begin
      bad++;
      $display("FAIL R9: reset valid=%b data=%h expected valid=0 data=0", rd_valid, rdata);
    end
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    checks++;
    if (k_phase !== 1'b1 || rd_valid !== 1'b0) begin
      bad++;
      $display("FAIL R9: after reset k_phase=%b valid=%b expected 1 0", k_phase, rd_valid);
    end
    e = 0;
    exp_d.delete();
    exp_tag.delete();
    last_out = '0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  initial begin
    #500000;
    bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; lat_mode = 1'b0; rd_sel_n = 1'b1; wr_sel_n = 1'b1;
    addr = '0; wdata = '0; byte_wr_n = '1; last_out = '0;
    repeat (3) @(negedge clk);
    do_reset();

    // R3: fill every address with full-lane writes, then read back in bursts
    for (int a = 0; a < 16; a++) wr(a, pat(a, 0), pat(a, 1), '0, '0);
    for (int a = 0; a < 16; a++) rd(a, "R3");
    idle(2);

    // R1: concurrent read and write to different addresses
    for (int a = 0; a < 4; a++)
      cyc(1, a, 1, a + 8, pat(a, 20), pat(a, 21), '0, '0, 0, 1, "R1");
    for (int a = 8; a < 12; a++) rd(a, "R1");
    idle(2);

    // R7: same-cycle, write-then-read, read-then-write
    cyc(1, 5, 1, 5, pat(5, 30), pat(5, 31), '0, '0, 0, 1, "R7");
    wr(6, pat(6, 30), pat(6, 31), '0, '0);
    rd(6, "R7");
    rd(7, "R7");
    wr(7, pat(7, 30), pat(7, 31), '0, '0);
    rd(7, "R7");
    cyc(1, 12, 1, 12, pat(12, 40), pat(12, 41), 4'b0110, 4'b1001, 0, 1, "R7");
    idle(2);

    // R6: lane masks on both words, back-to-back to one address
    wr(8, pat(8, 50), pat(8, 51), 4'b1010, 4'b0101);
    wr(8, pat(8, 52), pat(8, 53), 4'b1110, 4'b0111);
    rd(8, "R6");
    wr(9, pat(9, 50), pat(9, 51), 4'b1111, 4'b0000);
    rd(9, "R6");
    idle(2);

    // R5: deselected ports, selects and addresses on complementary edges
    idle_tag = "R5";
    cyc(0, 3, 0, 3, pat(3, 60), pat(3, 61), '0, '0, 1, 1, "R5");
    cyc(0, 4, 0, 4, pat(4, 60), pat(4, 61), '0, '0, 1, 1, "R5");
    idle(2);
    rd(3, "R5");
    rd(4, "R5");
    idle(2);
    idle_tag = "R8";

    // R4: long latency, back-to-back and concurrent
    lat_mode = 1'b1;
    for (int a = 0; a < 6; a++) rd(a, "R4");
    cyc(1, 13, 1, 13, pat(13, 70), pat(13, 71), '0, '0, 0, 1, "R4");
    rd(13, "R4");
    idle(1);
    rd(14, "R4");
    idle(3);
    lat_mode = 1'b0;
    rd(15, "R4");
    idle(2);

    // R9: reset discards an in-flight read and a pending write
    cyc(1, 10, 1, 10, pat(10, 80), pat(10, 81), '0, '0, 0, 0, "R9");
    do_reset();
    rd(10, "R9");
    idle(3);

    finish_run();
  end
endmodule